// File: doc/BRIEF.md
# Internal Data Access Unit

This block turns operand addresses of an 8-bit microcontroller core into accesses on a 256-byte internal data RAM or on a port to the special-function register (SFR) space outside it. The instruction decoder presents one request at a time. A request carries a mode, an 8-bit address, a write enable and write data. The block resolves direct, indirect, register-bank and bit operands. It merges single-bit writes into their byte. It also owns the stack pointer and sequences byte and 16-bit pushes and pops on the same RAM.

Most operations complete in one cycle. A 16-bit stack operation, or a bit write to an SFR, holds `busy_o` high for one cycle before it completes. Every completed operation pulses `done_o` for one cycle, and read results appear on `rdata_o` or `rbit_o` in that same cycle. The accumulator sits in SFR space at a parameterised address. The core holds it, so its writes leave on a dedicated output, and its reads come back on `acc_i` instead of going through the SFR port.

Top module: `idata_access_unit`

## Requirements
- R1: In direct mode (`req_mode_i`=0), an address below 0x80 reads or writes internal RAM and leaves the SFR port idle. An address of 0x80 or above reads through `sfr_re_o` or writes through `sfr_we_o`, with `sfr_addr_o` equal to the address, in the request cycle.
- R2: Indirect mode (1) always accesses internal RAM at the full 8-bit address, including 0x80–0xFF, and never strobes the SFR port.
- R3: Register mode (2) accesses RAM byte `{bank_i, req_addr_i[2:0]}`, that is register n of bank b at 8*b + n, where `bank_i[1]` is the upper bank bit of the status word.
- R4: Bit mode (3) with a bit address below 0x80 addresses RAM byte 0x20 + addr[6:3], bit addr[2:0]. A write stores `req_wdata_i[0]` into that bit only and completes in one cycle. A read returns the bit on `rbit_o`.
- R5: A bit write at a bit address of 0x80 or above reads SFR byte `addr & 0xF8` in the request cycle. In the next cycle it writes that byte back with only bit addr[2:0] replaced.
- R6: A bit read from SFR bytes 0x80, 0x90, 0xA0 or 0xB0 returns the addressed bit of `sfr_rdata_i` ANDed with the same bit of `sfr_latch_i`. Other SFR bytes return the `sfr_rdata_i` bit alone.
- R7: Push (4) first increments the stack pointer and then writes the low data byte at the new value. Pop (5) returns the byte at the current stack pointer and then decrements it. The stack pointer wraps modulo 256.
- R8: After reset, `sp_o` is 0x07, and `busy_o` and `done_o` are low.
- R9: A 16-bit push (6) writes `req_wdata_i[7:0]` and then `req_wdata_i[15:8]` on two pre-incremented addresses. A 16-bit pop (7) returns the first byte popped in `rdata_o[15:8]` and the second in `rdata_o[7:0]`.
- R10: A single-cycle operation raises `done_o` in the cycle after the request. A 16-bit stack operation or an SFR bit write holds `busy_o` for one cycle and raises `done_o` in the cycle after that.
- R11: A request presented while `busy_o` is high is ignored. It changes neither RAM, nor the stack pointer, nor the SFR port.
- R12: A direct or bit write to the accumulator address `ACC_ADDR` (0xE0) drives `acc_we_o` and `acc_wdata_o`, never `sfr_we_o`. A direct or bit read of that byte returns `acc_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_mode_i | input | 3 | Access mode (encodings in R1–R9) |
| req_addr_i | input | 8 | Direct, indirect, register or bit address |
| req_we_i | input | 1 | Write request for the direct, indirect, register and bit modes |
| req_wdata_i | input | 16 | Write data; bit value in [0]; high byte for 16-bit push |
| bank_i | input | 2 | Register-bank select from the status word |
| acc_i | input | 8 | Current accumulator value |
| sfr_rdata_i | input | 8 | SFR read data (pin value for ports) |
| sfr_latch_i | input | 8 | Port output-latch value at `sfr_addr_o` |
| sfr_addr_o | output | 8 | SFR address |
| sfr_re_o | output | 1 | SFR read strobe |
| sfr_we_o | output | 1 | SFR write strobe |
| sfr_wdata_o | output | 8 | SFR write data |
| acc_we_o | output | 1 | Accumulator write strobe |
| acc_wdata_o | output | 8 | Accumulator write data |
| rdata_o | output | 16 | Read result, valid with `done_o` |
| rbit_o | output | 1 | Bit read result, valid with `done_o` |
| sp_o | output | 8 | Stack pointer |
| busy_o | output | 1 | Second cycle of a two-cycle operation |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions check the following on every cycle:
- the stack pointer moves by exactly one on each accepted byte push or pop;
- a busy cycle is always followed by completion;
- the accumulator address never appears on an SFR write;
- indirect accesses and low direct addresses never touch the SFR port;
- no SFR read is issued during a busy cycle.

Only the directed scenarios can show the data-side facts:
- the bank arithmetic and the bit-to-byte mapping;
- the merged byte written back to an SFR, and the AND with the port latch;
- the byte order of 16-bit stack traffic and the wrap of the stack pointer at 0xFF;
- that a write presented during a busy cycle leaves memory untouched.

// File: rtl/idata_pkg.sv
package idata_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned AW = 8;
  localparam int unsigned PW = $clog2(DW);

  typedef enum logic [2:0] {
    AM_DIRECT   = 3'd0,
    AM_INDIRECT = 3'd1,
    AM_REG      = 3'd2,
    AM_BIT      = 3'd3,
    AM_PUSH     = 3'd4,
    AM_POP      = 3'd5,
    AM_PUSH16   = 3'd6,
    AM_POP16    = 3'd7
  } am_e;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_SECOND = 1'b1
  } st_e;
endpackage

// File: rtl/idata_addr_map.sv
module idata_addr_map import idata_pkg::*; #(
  parameter logic [AW-1:0] BIT_BASE = 8'h20
) (
  input  am_e           mode_i,
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    bank_i,
  output logic          to_sfr_o,
  output logic [AW-1:0] ram_addr_o,
  output logic [AW-1:0] sfr_addr_o,
  output logic [PW-1:0] pos_o,
  output logic          is_port_o
);
  always_comb begin
    to_sfr_o   = 1'b0;
    ram_addr_o = addr_i;
    sfr_addr_o = addr_i;
    pos_o      = addr_i[PW-1:0];
    unique case (mode_i)
      AM_DIRECT:   to_sfr_o = addr_i[AW-1];
      AM_INDIRECT: to_sfr_o = 1'b0;
      AM_REG:      ram_addr_o = {{(AW-5){1'b0}}, bank_i, addr_i[2:0]};
      AM_BIT: begin
        to_sfr_o   = addr_i[AW-1];
        ram_addr_o = BIT_BASE + {{(PW+1){1'b0}}, addr_i[AW-2:PW]};
        sfr_addr_o = {addr_i[AW-1:PW], {PW{1'b0}}};
      end
      default:     to_sfr_o = 1'b0;
    endcase
  end

  // port SFRs sit at 0x80, 0x90, 0xA0, 0xB0
  assign is_port_o = sfr_addr_o[7] && !sfr_addr_o[6] && (sfr_addr_o[3:0] == 4'h0);
endmodule

// File: rtl/idata_ram.sv
module idata_ram #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/idata_bit_merge.sv
module idata_bit_merge #(
  parameter int unsigned DW = 8,
  localparam int unsigned PW = $clog2(DW)
) (
  input  logic [DW-1:0] byte_i,
  input  logic [PW-1:0] pos_i,
  input  logic          val_i,
  output logic [DW-1:0] byte_o,
  output logic          bit_o
);
  for (genvar i = 0; i < DW; i++) begin : g_bit
    assign byte_o[i] = (pos_i == PW'(i)) ? val_i : byte_i[i];
  end
  assign bit_o = byte_i[pos_i];
endmodule

// File: rtl/idata_access_unit.sv
module idata_access_unit import idata_pkg::*; #(
  parameter logic [AW-1:0] ACC_ADDR = 8'hE0,
  parameter logic [AW-1:0] SP_RESET = 8'h07
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  logic [2:0]      req_mode_i,
  input  logic [AW-1:0]   req_addr_i,
  input  logic            req_we_i,
  input  logic [2*DW-1:0] req_wdata_i,
  input  logic [1:0]      bank_i,
  input  logic [DW-1:0]   acc_i,
  input  logic [DW-1:0]   sfr_rdata_i,
  input  logic [DW-1:0]   sfr_latch_i,
  output logic [AW-1:0]   sfr_addr_o,
  output logic            sfr_re_o,
  output logic            sfr_we_o,
  output logic [DW-1:0]   sfr_wdata_o,
  output logic            acc_we_o,
  output logic [DW-1:0]   acc_wdata_o,
  output logic [2*DW-1:0] rdata_o,
  output logic            rbit_o,
  output logic [AW-1:0]   sp_o,
  output logic            busy_o,
  output logic            done_o
);
  am_e mode;
  assign mode = am_e'(req_mode_i);

  st_e             state_q, state_d;
  am_e             op_q, op_d;
  logic [AW-1:0]   sp_q, sp_d, sp_inc, sp_dec;
  logic [DW-1:0]   hold_q, hold_d;
  logic [AW-1:0]   hold_addr_q, hold_addr_d;
  logic            hold_acc_q, hold_acc_d;
  logic [2*DW-1:0] rdata_q, rdata_d;
  logic            rbit_q, rbit_d, done_q, done_d;

  logic            m_sfr, m_port;
  logic [AW-1:0]   m_ram_addr, m_sfr_addr;
  logic [PW-1:0]   m_pos;

  logic            ram_we;
  logic [AW-1:0]   ram_waddr, ram_raddr;
  logic [DW-1:0]   ram_wdata, ram_rdata;

  logic            is_acc, accept;
  logic [DW-1:0]   sfr_val, merge_in, merge_out;
  logic            merge_bit;

  idata_addr_map u_map (
    .mode_i     (mode),
    .addr_i     (req_addr_i),
    .bank_i     (bank_i),
    .to_sfr_o   (m_sfr),
    .ram_addr_o (m_ram_addr),
    .sfr_addr_o (m_sfr_addr),
    .pos_o      (m_pos),
    .is_port_o  (m_port)
  );

  idata_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk_i   (clk_i),
    .we_i    (ram_we),
    .waddr_i (ram_waddr),
    .wdata_i (ram_wdata),
    .raddr_i (ram_raddr),
    .rdata_o (ram_rdata)
  );

  idata_bit_merge #(.DW(DW)) u_merge (
    .byte_i (merge_in),
    .pos_i  (m_pos),
    .val_i  (req_wdata_i[0]),
    .byte_o (merge_out),
    .bit_o  (merge_bit)
  );

  assign accept   = req_valid_i && (state_q == ST_IDLE);
  assign sp_inc   = sp_q + AW'(1);
  assign sp_dec   = sp_q - AW'(1);
  assign is_acc   = (m_sfr_addr == ACC_ADDR);
  assign sfr_val  = is_acc ? acc_i : sfr_rdata_i;
  assign merge_in = m_sfr ? sfr_val : ram_rdata;

  always_comb begin
    state_d     = state_q;
    op_d        = op_q;
    sp_d        = sp_q;
    hold_d      = hold_q;
    hold_addr_d = hold_addr_q;
    hold_acc_d  = hold_acc_q;
    rdata_d     = rdata_q;
    rbit_d      = rbit_q;
    done_d      = 1'b0;
    ram_we      = 1'b0;
    ram_waddr   = m_ram_addr;
    ram_wdata   = req_wdata_i[DW-1:0];
    ram_raddr   = m_ram_addr;
    sfr_addr_o  = '0;
    sfr_re_o    = 1'b0;
    sfr_we_o    = 1'b0;
    sfr_wdata_o = '0;
    acc_we_o    = 1'b0;
    acc_wdata_o = '0;

    if (state_q == ST_IDLE) begin
      if (accept) begin
        unique case (mode)
          AM_DIRECT, AM_INDIRECT, AM_REG: begin
            done_d = 1'b1;
            if (m_sfr) begin
              if (req_we_i) begin
                if (is_acc) begin
                  acc_we_o    = 1'b1;
                  acc_wdata_o = req_wdata_i[DW-1:0];
                end else begin
                  sfr_we_o    = 1'b1;
                  sfr_addr_o  = m_sfr_addr;
                  sfr_wdata_o = req_wdata_i[DW-1:0];
                end
              end else begin
                sfr_re_o   = !is_acc;
                sfr_addr_o = m_sfr_addr;
                rdata_d    = {{DW{1'b0}}, sfr_val};
              end
            end else if (req_we_i) begin
              ram_we = 1'b1;
            end else begin
              rdata_d = {{DW{1'b0}}, ram_rdata};
            end
          end
          AM_BIT: begin
            if (m_sfr) begin
              sfr_re_o   = !is_acc;
              sfr_addr_o = m_sfr_addr;
              if (req_we_i) begin
                hold_d      = merge_out;
                hold_addr_d = m_sfr_addr;
                hold_acc_d  = is_acc;
                op_d        = AM_BIT;
                state_d     = ST_SECOND;
              end else begin
                rbit_d = merge_bit & (m_port ? sfr_latch_i[m_pos] : 1'b1);
                done_d = 1'b1;
              end
            end else begin
              done_d = 1'b1;
              if (req_we_i) begin
                ram_we    = 1'b1;
                ram_wdata = merge_out;
              end else begin
                rbit_d = merge_bit;
              end
            end
          end
          AM_PUSH: begin
            ram_we    = 1'b1;
            ram_waddr = sp_inc;
            sp_d      = sp_inc;
            done_d    = 1'b1;
          end
          AM_POP: begin
            ram_raddr = sp_q;
            rdata_d   = {{DW{1'b0}}, ram_rdata};
            sp_d      = sp_dec;
            done_d    = 1'b1;
          end
          AM_PUSH16: begin
            ram_we    = 1'b1;
            ram_waddr = sp_inc;
            sp_d      = sp_inc;
            hold_d    = req_wdata_i[2*DW-1:DW];
            op_d      = AM_PUSH16;
            state_d   = ST_SECOND;
          end
          AM_POP16: begin
            ram_raddr = sp_q;
            hold_d    = ram_rdata;
            sp_d      = sp_dec;
            op_d      = AM_POP16;
            state_d   = ST_SECOND;
          end
          default: ;
        endcase
      end
    end else begin
      state_d = ST_IDLE;
      done_d  = 1'b1;
      unique case (op_q)
        AM_BIT: begin
          if (hold_acc_q) begin
            acc_we_o    = 1'b1;
            acc_wdata_o = hold_q;
          end else begin
            sfr_we_o    = 1'b1;
            sfr_addr_o  = hold_addr_q;
            sfr_wdata_o = hold_q;
          end
        end
        AM_PUSH16: begin
          ram_we    = 1'b1;
          ram_waddr = sp_inc;
          ram_wdata = hold_q;
          sp_d      = sp_inc;
        end
        AM_POP16: begin
          ram_raddr = sp_q;
          rdata_d   = {hold_q, ram_rdata};
          sp_d      = sp_dec;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      op_q        <= AM_DIRECT;
      sp_q        <= SP_RESET;
      hold_q      <= '0;
      hold_addr_q <= '0;
      hold_acc_q  <= 1'b0;
      rdata_q     <= '0;
      rbit_q      <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      state_q     <= state_d;
      op_q        <= op_d;
      sp_q        <= sp_d;
      hold_q      <= hold_d;
      hold_addr_q <= hold_addr_d;
      hold_acc_q  <= hold_acc_d;
      rdata_q     <= rdata_d;
      rbit_q      <= rbit_d;
      done_q      <= done_d;
    end
  end

  assign rdata_o = rdata_q;
  assign rbit_o  = rbit_q;
  assign sp_o    = sp_q;
  assign busy_o  = (state_q == ST_SECOND);
  assign done_o  = done_q;
endmodule

// File: rtl/idata_access_chk.sv
module idata_access_chk import idata_pkg::*; #(
  parameter logic [AW-1:0] ACC_ADDR = 8'hE0
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic [2:0]    req_mode_i,
  input logic [AW-1:0] req_addr_i,
  input logic [AW-1:0] sfr_addr_o,
  input logic          sfr_re_o,
  input logic          sfr_we_o,
  input logic          acc_we_o,
  input logic [AW-1:0] sp_o,
  input logic          busy_o,
  input logic          done_o
);
  logic acc_ok;
  assign acc_ok = req_valid_i && !busy_o;

  // R7
  push_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_ok && req_mode_i == AM_PUSH) |=> (sp_o == AW'($past(sp_o) + AW'(1))));

  // R7
  pop_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_ok && req_mode_i == AM_POP) |=> (sp_o == AW'($past(sp_o) - AW'(1))));

  // R10
  busy_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (done_o && !busy_o));

  // R12
  acc_iso_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sfr_we_o |-> (sfr_addr_o != ACC_ADDR));

  // R2
  ind_no_sfr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_ok && req_mode_i == AM_INDIRECT) |-> (!sfr_re_o && !sfr_we_o));

  // R1
  ram_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_ok && req_mode_i == AM_DIRECT && !req_addr_i[AW-1]) |-> (!sfr_re_o && !sfr_we_o && !acc_we_o));

  // R11
  busy_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !sfr_re_o);
endmodule

bind idata_access_unit idata_access_chk #(.ACC_ADDR(ACC_ADDR)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_mode_i  (req_mode_i),
  .req_addr_i  (req_addr_i),
  .sfr_addr_o  (sfr_addr_o),
  .sfr_re_o    (sfr_re_o),
  .sfr_we_o    (sfr_we_o),
  .acc_we_o    (acc_we_o),
  .sp_o        (sp_o),
  .busy_o      (busy_o),
  .done_o      (done_o)
);

// File: tb/idata_access_unit_tb.sv
module idata_access_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] M_DIR = 3'd0, M_IND = 3'd1, M_REG = 3'd2, M_BIT = 3'd3,
                         M_PUSH = 3'd4, M_POP = 3'd5, M_PUSH16 = 3'd6, M_POP16 = 3'd7;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        valid = 1'b0, we = 1'b0;
  logic [2:0]  mode = 3'd0;
  logic [7:0]  addr = 8'h00;
  logic [15:0] wdata = 16'h0;
  logic [1:0]  bank = 2'b00;
  logic [7:0]  acc_q;
  logic [7:0]  sfr_mem [256];
  logic [7:0]  latch_mem [256];

  logic [7:0]  sfr_addr, sfr_wdata, acc_wdata, sp;
  logic        sfr_re, sfr_we, acc_we, rbit, busy, done;
  logic [15:0] rdata;
  logic [7:0]  sfr_rdata, sfr_latch;

  int n_chk = 0, n_bad = 0;
  bit c_sfr_we, c_sfr_re, c_acc_we, c_busy;
  logic [7:0] c_waddr, c_wdata;
  int lat;
  logic [7:0] sp0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sfr_rdata = sfr_mem[sfr_addr];
  assign sfr_latch = latch_mem[sfr_addr];

  always @(posedge clk) if (sfr_we) sfr_mem[sfr_addr] <= sfr_wdata;

  always @(posedge clk or negedge rst_n)
    if (!rst_n) acc_q <= 8'h00;
    else if (acc_we) acc_q <= acc_wdata;

  idata_access_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_mode_i(mode),
    .req_addr_i(addr), .req_we_i(we), .req_wdata_i(wdata), .bank_i(bank),
    .acc_i(acc_q), .sfr_rdata_i(sfr_rdata), .sfr_latch_i(sfr_latch),
    .sfr_addr_o(sfr_addr), .sfr_re_o(sfr_re), .sfr_we_o(sfr_we),
    .sfr_wdata_o(sfr_wdata), .acc_we_o(acc_we), .acc_wdata_o(acc_wdata),
    .rdata_o(rdata), .rbit_o(rbit), .sp_o(sp), .busy_o(busy), .done_o(done)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sample();
    if (sfr_we) begin c_sfr_we = 1; c_waddr = sfr_addr; c_wdata = sfr_wdata; end
    if (sfr_re) c_sfr_re = 1;
    if (acc_we) c_acc_we = 1;
    if (busy) c_busy = 1;
  endtask

  task automatic op(input logic [2:0] m, input logic [7:0] a, input logic w, input logic [15:0] d);
    @(negedge clk);
    valid = 1; mode = m; addr = a; we = w; wdata = d;
    c_sfr_we = 0; c_sfr_re = 0; c_acc_we = 0; c_busy = 0;
    #1 sample();
    @(negedge clk);
    valid = 0; we = 0; lat = 1;
    while (!done && lat < 6) begin
      sample();
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic t_reset();
    chk("R8 sp reset", {8'h0, sp}, 16'h0007);
    chk("R8 busy reset", {15'h0, busy}, 16'h0);
    chk("R8 done reset", {15'h0, done}, 16'h0);
  endtask

  task automatic t_direct();
    op(M_DIR, 8'h12, 1, 16'h00A5);
    chk("R1 ram write no sfr", {14'h0, c_sfr_we, c_sfr_re}, 16'h0);
    chk("R10 single latency", lat[15:0], 16'd1);
    op(M_DIR, 8'h12, 0, 0);
    chk("R1 ram read", rdata, 16'h00A5);
    op(M_DIR, 8'h90, 1, 16'h003C);
    chk("R1 sfr write strobe", {7'h0, c_sfr_we, c_waddr}, 16'h0190);
    chk("R1 sfr write data", {8'h0, c_wdata}, 16'h003C);
    op(M_DIR, 8'h90, 0, 0);
    chk("R1 sfr read", {7'h0, c_sfr_re, rdata[7:0]}, 16'h013C);
  endtask

  task automatic t_indirect();
    op(M_IND, 8'h90, 1, 16'h0077);
    chk("R2 indirect no sfr", {14'h0, c_sfr_we, c_sfr_re}, 16'h0);
    op(M_IND, 8'h90, 0, 0);
    chk("R2 indirect high ram", rdata, 16'h0077);
    op(M_DIR, 8'h90, 0, 0);
    chk("R2 sfr untouched", rdata, 16'h003C);
  endtask

  task automatic t_regbank();
    bank = 2'b10;
    op(M_REG, 8'h03, 1, 16'h005A);
    op(M_IND, 8'h13, 0, 0);
    chk("R3 bank2 r3 at 0x13", rdata, 16'h005A);
    bank = 2'b01;
    op(M_IND, 8'h0B, 1, 16'h00C3);
    op(M_REG, 8'h03, 0, 0);
    chk("R3 bank1 r3 at 0x0B", rdata, 16'h00C3);
    bank = 2'b00;
  endtask

  task automatic t_ram_bit();
    op(M_IND, 8'h21, 1, 16'h0000);
    op(M_BIT, 8'h0B, 1, 16'h0001);
    chk("R4 ram bit write latency", lat[15:0], 16'd1);
    op(M_IND, 8'h21, 0, 0);
    chk("R4 ram bit byte 0x21", rdata, 16'h0008);
    op(M_BIT, 8'h0B, 0, 0);
    chk("R4 ram bit read set", {15'h0, rbit}, 16'h1);
    op(M_BIT, 8'h0A, 0, 0);
    chk("R4 ram bit read clear", {15'h0, rbit}, 16'h0);
  endtask

  task automatic t_sfr_rmw();
    op(M_DIR, 8'hC8, 1, 16'h000F);
    op(M_BIT, 8'hCE, 1, 16'h0001);
    chk("R5 rmw write", {7'h0, c_sfr_we, c_waddr}, 16'h01C8);
    chk("R5 rmw data", {8'h0, c_wdata}, 16'h004F);
    chk("R5 rmw read issued", {15'h0, c_sfr_re}, 16'h1);
    chk("R10 rmw busy+latency", {c_busy, lat[14:0]}, 16'h8002);
    op(M_BIT, 8'hC9, 1, 16'h0000);
    chk("R5 rmw clear", {8'h0, sfr_mem[8'hC8]}, 16'h004D);
  endtask

  task automatic t_port_bit();
    op(M_DIR, 8'h80, 1, 16'h00FF);
    op(M_BIT, 8'h81, 0, 0);
    chk("R6 port pin&latch 1", {15'h0, rbit}, 16'h1);
    op(M_BIT, 8'h85, 0, 0);
    chk("R6 port latch low", {15'h0, rbit}, 16'h0);
    op(M_BIT, 8'hCE, 0, 0);
    chk("R6 non-port ignores latch", {15'h0, rbit}, 16'h1);
  endtask

  task automatic t_stack();
    op(M_PUSH, 8'h00, 0, 16'h0011);
    chk("R7 push sp", {8'h0, sp}, 16'h0008);
    op(M_IND, 8'h08, 0, 0);
    chk("R7 push preinc", rdata, 16'h0011);
    op(M_POP, 8'h00, 0, 0);
    chk("R7 pop data", rdata, 16'h0011);
    chk("R7 pop sp", {8'h0, sp}, 16'h0007);
  endtask

  task automatic t_stack16();
    op(M_PUSH16, 8'h00, 0, 16'hBEEF);
    chk("R9 push16 sp/latency", {sp, lat[7:0]}, 16'h0902);
    op(M_IND, 8'h08, 0, 0);
    chk("R9 push16 low first", rdata, 16'h00EF);
    op(M_IND, 8'h09, 0, 0);
    chk("R9 push16 high second", rdata, 16'h00BE);
    op(M_POP16, 8'h00, 0, 0);
    chk("R9 pop16 order", rdata, 16'hBEEF);
    chk("R9 pop16 sp", {8'h0, sp}, 16'h0007);
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 8; i++) op(M_POP, 8'h00, 0, 0);
    chk("R7 sp wrap down", {8'h0, sp}, 16'h00FF);
    op(M_PUSH, 8'h00, 0, 16'h0099);
    chk("R7 sp wrap up", {8'h0, sp}, 16'h0000);
    op(M_IND, 8'h00, 0, 0);
    chk("R7 wrap write ram0", rdata, 16'h0099);
    op(M_POP, 8'h00, 0, 0);
    chk("R7 wrap pop", {rdata[7:0], sp}, 16'h99FF);
  endtask

  task automatic t_busy_ignore();
    op(M_DIR, 8'h40, 1, 16'h0001);
    @(negedge clk);
    sp0 = sp;
    valid = 1; mode = M_PUSH16; addr = 8'h00; we = 0; wdata = 16'h1234;
    @(negedge clk);
    chk("R11 busy raised", {15'h0, busy}, 16'h1);
    mode = M_DIR; addr = 8'h40; we = 1; wdata = 16'h00EE;
    @(negedge clk);
    chk("R11 done after busy", {15'h0, done}, 16'h1);
    valid = 0; we = 0;
    chk("R11 sp moved by two", {8'h0, sp}, {8'h0, 8'(sp0 + 8'd2)});
    op(M_DIR, 8'h40, 0, 0);
    chk("R11 ignored write", rdata, 16'h0001);
  endtask

  task automatic t_acc();
    op(M_DIR, 8'hE0, 1, 16'h0081);
    chk("R12 acc write routed", {14'h0, c_acc_we, c_sfr_we}, 16'h0002);
    chk("R12 acc value", {8'h0, acc_q}, 16'h0081);
    op(M_DIR, 8'hE0, 0, 0);
    chk("R12 acc read", {7'h0, c_sfr_re, rdata[7:0]}, 16'h0081);
    op(M_BIT, 8'hE1, 1, 16'h0001);
    chk("R12 acc bit write", {6'h0, c_acc_we, c_sfr_we, acc_q}, 16'h0283);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) latch_mem[i] = 8'h00;
    latch_mem[8'h80] = 8'h0F;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_direct();
    t_indirect();
    t_regbank();
    t_ram_bit();
    t_sfr_rmw();
    t_port_bit();
    t_stack();
    t_stack16();
    t_wrap();
    t_busy_ignore();
    t_acc();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule